// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block gives two ports, each on its own clock, a pair of single-word message registers that sit beside the main data queue. One register carries a word from port A to port B and the other carries a word from port B to port A. A port addresses a mailbox by pulling its chip select low and raising its mailbox select. The direction input then picks a store or a fetch. When mailbox select is low, the access belongs to the queue path: the block leaves it alone and passes that port's queue output word straight through to the port's data output.

Each register has an occupancy flag, and each side sees its own copy of it. The writer stores a word and its own copy of the flag rises on the same edge. The reader's copy follows through a two-stage synchronizer. A fetch by the reader while its copy is set acknowledges the word. That clears the reader's copy at once, and the writer's copy follows after the acknowledge has crossed back. A fetch does not destroy the stored word, and no byte reordering is ever applied. While the writer's flag is set, further stores are refused. The handshake uses one toggle per direction, and the stored word cannot change while the other side may be sampling it.

Top module: `mbox_pair`

## Requirements
- R1: With cs_a_n=0, dir_a=1 and msel_a=1 at a rising clk_a edge, and ab_full_a low, din_a is stored in the A-to-B mailbox.
- R2: With cs_b_n=0, dir_b=0 and msel_b=1 at a rising clk_b edge, and ba_full_b low, din_b is stored in the B-to-A mailbox.
- R3: A port's dout shows the opposite-direction mailbox while its chip select is low, its direction reads (dir_a=0 on A, dir_b=1 on B) and its msel is high; otherwise dout equals that port's fifo_q input.
- R4: The writer-side flag (ab_full_a or ba_full_b) is high right after the edge that accepts a mailbox store.
- R5: The reader-side flag (ab_full_b or ba_full_a) rises on the second reader-clock edge after the accepting write edge.
- R6: A mailbox read while the reader-side flag is high clears that flag right after the read edge, and the writer-side flag clears on the second writer-clock edge after the read edge.
- R7: A mailbox store while the writer-side flag is high is ignored, and the stored word keeps its earlier value.
- R8: Reading a mailbox leaves its contents unchanged; a repeated read returns the same word.
- R9: Mailbox words pass bit for bit, with bit i of the written word appearing as bit i of the read word and no byte or half-word reordering.
- R10: Reset (rst_a_n and rst_b_n low together) clears all four flags and both mailbox words to zero.
- R11: An access with msel low, whether a write or a read, changes no mailbox word and no flag.
- R12: A mailbox read while the reader-side flag is low sends no acknowledge, so the writer-side flag is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous active-low reset |
| cs_a_n | input | 1 | Port A chip select, active low |
| dir_a | input | 1 | Port A direction: 1 write, 0 read |
| msel_a | input | 1 | Port A mailbox select: 1 mailbox, 0 queue path |
| din_a | input | DATA_W | Port A write data |
| fifo_q_a | input | DATA_W | Queue output word presented on port A |
| dout_a | output | DATA_W | Port A read data |
| ab_full_a | output | 1 | A-to-B mailbox occupied, clk_a domain |
| ba_full_a | output | 1 | B-to-A mailbox holds unread mail, clk_a domain |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous active-low reset |
| cs_b_n | input | 1 | Port B chip select, active low |
| dir_b | input | 1 | Port B direction: 1 read, 0 write |
| msel_b | input | 1 | Port B mailbox select: 1 mailbox, 0 queue path |
| din_b | input | DATA_W | Port B write data |
| fifo_q_b | input | DATA_W | Queue output word presented on port B |
| dout_b | output | DATA_W | Port B read data |
| ba_full_b | output | 1 | B-to-A mailbox occupied, clk_b domain |
| ab_full_b | output | 1 | A-to-B mailbox holds unread mail, clk_b domain |

## Verification
The bench uses the defaults DATA_W=36 and SYNC_STAGES=2. Both clocks run at the same rate with a fixed 3 ns phase offset. Because the offset is fixed, the crossing delay is known to the edge, so the checks can require each flag to hold on the first opposite-domain edge and to change on the second, in both directions. With 36-bit words, asymmetric patterns that span all nine nibbles show any lane swap. Refused stores, the non-destructive reread, and reset in the middle of a transfer all fall within the same short run.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_QUEUE = 2'd1,
    ACC_MB_WR = 2'd2,
    ACC_MB_RD = 2'd3
  } acc_e;

  // wr_level: level of the direction input that means "store" on this port
  function automatic acc_e decode_acc(input logic cs_n, input logic dir,
                                      input logic msel, input logic wr_level);
    acc_e res;
    if (cs_n)       res = ACC_NONE;
    else if (!msel) res = ACC_QUEUE;
    else if (dir == wr_level) res = ACC_MB_WR;
    else            res = ACC_MB_RD;
    return res;
  endfunction

endpackage

// File: rtl/mbox_bit_sync.sv
module mbox_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = d_i;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
  import mbox_pkg::*;
#(
  parameter logic WR_LEVEL = 1'b1
) (
  input  logic cs_n,
  input  logic dir,
  input  logic msel,
  output logic mb_wr,
  output logic mb_rd
);

  acc_e acc;

  always_comb begin
    acc   = decode_acc(cs_n, dir, msel, WR_LEVEL);
    mb_wr = (acc == ACC_MB_WR);
    mb_rd = (acc == ACC_MB_RD);
  end

endmodule

// File: rtl/mbox_chan.sv
module mbox_chan #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_w,
  input  logic              rst_w_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full_w,
  input  logic              clk_r,
  input  logic              rst_r_n,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              full_r
);

  logic              wr_tgl_q, wr_tgl_d;
  logic              rd_tgl_q, rd_tgl_d;
  logic [DATA_W-1:0] word_q;
  logic              wr_tgl_sync;
  logic              rd_tgl_sync;
  logic              wr_acc;
  logic              rd_ack;

  // writer domain: flag is the toggle mismatch seen from the writer
  always_comb begin
    full_w   = wr_tgl_q ^ rd_tgl_sync;
    wr_acc   = wr_req & ~full_w;
    wr_tgl_d = wr_tgl_q ^ wr_acc;
  end

  always_ff @(posedge clk_w or negedge rst_w_n) begin
    if (!rst_w_n) begin
      wr_tgl_q <= 1'b0;
      word_q   <= '0;
    end else begin
      wr_tgl_q <= wr_tgl_d;
      if (wr_acc) word_q <= wr_data;
    end
  end

  // reader domain: acknowledge only mail that has been seen
  always_comb begin
    full_r   = wr_tgl_sync ^ rd_tgl_q;
    rd_ack   = rd_req & full_r;
    rd_tgl_d = rd_tgl_q ^ rd_ack;
  end

  always_ff @(posedge clk_r or negedge rst_r_n) begin
    if (!rst_r_n) rd_tgl_q <= 1'b0;
    else          rd_tgl_q <= rd_tgl_d;
  end

  // word is held stable while either copy of the flag is set
  assign rd_data = word_q;

  mbox_bit_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk  (clk_r),
    .rst_n(rst_r_n),
    .d_i  (wr_tgl_q),
    .q_o  (wr_tgl_sync)
  );

  mbox_bit_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk  (clk_w),
    .rst_n(rst_w_n),
    .d_i  (rd_tgl_q),
    .q_o  (rd_tgl_sync)
  );

  // R4
  store_sets_flag_chk: assert property (@(posedge clk_w) disable iff (!rst_w_n)
    wr_acc |=> full_w);

  // R7
  refused_store_keeps_word_chk: assert property (@(posedge clk_w) disable iff (!rst_w_n)
    (full_w && wr_req) |=> $stable(word_q));

  // R6
  read_clears_reader_flag_chk: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    rd_ack |=> !full_r);

  // R12
  empty_read_no_ack_chk: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    (rd_req && !full_r) |=> $stable(rd_tgl_q));

endmodule

// File: rtl/mbox_pair.sv
module mbox_pair #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic              cs_a_n,
  input  logic              dir_a,
  input  logic              msel_a,
  input  logic [DATA_W-1:0] din_a,
  input  logic [DATA_W-1:0] fifo_q_a,
  output logic [DATA_W-1:0] dout_a,
  output logic              ab_full_a,
  output logic              ba_full_a,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic              cs_b_n,
  input  logic              dir_b,
  input  logic              msel_b,
  input  logic [DATA_W-1:0] din_b,
  input  logic [DATA_W-1:0] fifo_q_b,
  output logic [DATA_W-1:0] dout_b,
  output logic              ba_full_b,
  output logic              ab_full_b
);

  localparam int RST_STAGES = 2;

  logic              rst_a_sync_n, rst_b_sync_n;
  logic              a_mb_wr, a_mb_rd, b_mb_wr, b_mb_rd;
  logic [DATA_W-1:0] ab_word, ba_word;

  // asynchronous assert, synchronous release in each domain
  mbox_bit_sync #(.STAGES(RST_STAGES)) u_rst_a (
    .clk(clk_a), .rst_n(rst_a_n), .d_i(1'b1), .q_o(rst_a_sync_n)
  );
  mbox_bit_sync #(.STAGES(RST_STAGES)) u_rst_b (
    .clk(clk_b), .rst_n(rst_b_n), .d_i(1'b1), .q_o(rst_b_sync_n)
  );

  mbox_port_dec #(.WR_LEVEL(1'b1)) u_dec_a (
    .cs_n(cs_a_n), .dir(dir_a), .msel(msel_a), .mb_wr(a_mb_wr), .mb_rd(a_mb_rd)
  );
  mbox_port_dec #(.WR_LEVEL(1'b0)) u_dec_b (
    .cs_n(cs_b_n), .dir(dir_b), .msel(msel_b), .mb_wr(b_mb_wr), .mb_rd(b_mb_rd)
  );

  mbox_chan #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ab (
    .clk_w  (clk_a),
    .rst_w_n(rst_a_sync_n),
    .wr_req (a_mb_wr),
    .wr_data(din_a),
    .full_w (ab_full_a),
    .clk_r  (clk_b),
    .rst_r_n(rst_b_sync_n),
    .rd_req (b_mb_rd),
    .rd_data(ab_word),
    .full_r (ab_full_b)
  );

  mbox_chan #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ba (
    .clk_w  (clk_b),
    .rst_w_n(rst_b_sync_n),
    .wr_req (b_mb_wr),
    .wr_data(din_b),
    .full_w (ba_full_b),
    .clk_r  (clk_a),
    .rst_r_n(rst_a_sync_n),
    .rd_req (a_mb_rd),
    .rd_data(ba_word),
    .full_r (ba_full_a)
  );

  // output steering: mailbox during a mailbox read, queue word otherwise
  always_comb begin
    dout_a = a_mb_rd ? ba_word : fifo_q_a;
    dout_b = b_mb_rd ? ab_word : fifo_q_b;
  end

endmodule

// File: tb/tb_mbox_pair.sv
module tb_mbox_pair;

  localparam int W = 36;
  localparam logic [W-1:0] QA = 36'hA_AAAA_0001;
  localparam logic [W-1:0] QB = 36'hB_BBBB_0002;

  logic clk_a, clk_b, rst_n;
  logic cs_a_n, dir_a, msel_a, cs_b_n, dir_b, msel_b;
  logic [W-1:0] din_a, din_b, dout_a, dout_b;
  logic ab_full_a, ba_full_a, ab_full_b, ba_full_b;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [W-1:0] q_ab[$];
  logic [W-1:0] q_ba[$];
  logic [W-1:0] last_ab = '0, last_ba = '0;

  mbox_pair #(.DATA_W(W), .SYNC_STAGES(2)) dut (
    .clk_a(clk_a), .rst_a_n(rst_n), .cs_a_n(cs_a_n), .dir_a(dir_a), .msel_a(msel_a),
    .din_a(din_a), .fifo_q_a(QA), .dout_a(dout_a), .ab_full_a(ab_full_a), .ba_full_a(ba_full_a),
    .clk_b(clk_b), .rst_b_n(rst_n), .cs_b_n(cs_b_n), .dir_b(dir_b), .msel_b(msel_b),
    .din_b(din_b), .fifo_q_b(QB), .dout_b(dout_b), .ba_full_b(ba_full_b), .ab_full_b(ab_full_b)
  );

  // 125 MHz on both ports, port B lagging by 3 ns
  initial begin clk_a = 0; forever #4 clk_a = ~clk_a; end
  initial begin clk_b = 0; #3; forever #4 clk_b = ~clk_b; end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic a_op(input logic dir, input logic msel, input logic [W-1:0] d,
                      output logic [W-1:0] seen);
    @(negedge clk_a);
    cs_a_n = 0; dir_a = dir; msel_a = msel; din_a = d;
    #1 seen = dout_a;
    @(negedge clk_a);
    cs_a_n = 1; dir_a = 0; msel_a = 0;
  endtask

  task automatic b_op(input logic dir, input logic msel, input logic [W-1:0] d,
                      output logic [W-1:0] seen);
    @(negedge clk_b);
    cs_b_n = 0; dir_b = dir; msel_b = msel; din_b = d;
    #1 seen = dout_b;
    @(negedge clk_b);
    cs_b_n = 1; dir_b = 1; msel_b = 0;
  endtask

  // driver: stores, pushing expected words when the store should be taken
  task automatic a_store(input logic [W-1:0] d, input bit take);
    logic [W-1:0] s;
    a_op(1'b1, 1'b1, d, s);
    if (take) q_ab.push_back(d);
  endtask

  task automatic b_store(input logic [W-1:0] d, input bit take);
    logic [W-1:0] s;
    b_op(1'b0, 1'b1, d, s);
    if (take) q_ba.push_back(d);
  endtask

  // monitor: fetches pop the scoreboard, or expect the held word again
  task automatic b_fetch(input string tag);
    logic [W-1:0] s, e;
    b_op(1'b1, 1'b1, '0, s);
    e = (q_ab.size() != 0) ? q_ab.pop_front() : last_ab;
    last_ab = e;
    chk(tag, s, e);
  endtask

  task automatic a_fetch(input string tag);
    logic [W-1:0] s, e;
    a_op(1'b0, 1'b1, '0, s);
    e = (q_ba.size() != 0) ? q_ba.pop_front() : last_ba;
    last_ba = e;
    chk(tag, s, e);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk_a);
    @(negedge clk_a); rst_n = 1;
    repeat (4) @(negedge clk_a);
    q_ab.delete(); q_ba.delete(); last_ab = '0; last_ba = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_a);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] s;
    cs_a_n = 1; dir_a = 0; msel_a = 0; din_a = '0;
    cs_b_n = 1; dir_b = 1; msel_b = 0; din_b = '0;
    do_reset();

    // R10 reset state
    chk("R10 ab_full_a", ab_full_a, 0); chk("R10 ab_full_b", ab_full_b, 0);
    chk("R10 ba_full_a", ba_full_a, 0); chk("R10 ba_full_b", ba_full_b, 0);
    b_fetch("R10 ab word zero");
    a_fetch("R10 ba word zero");
    // R12 fetch with empty flag sends no acknowledge
    @(negedge clk_a); @(negedge clk_a);
    chk("R12 ab_full_a after empty read", ab_full_a, 0);
    chk("R12 ba_full_b after empty read", ba_full_b, 0);

    // R3 queue path passes through
    a_op(1'b0, 1'b0, '0, s); chk("R3 dout_a queue", s, QA);
    b_op(1'b1, 1'b0, '0, s); chk("R3 dout_b queue", s, QB);

    // R11 queue-path write touches no mailbox
    a_op(1'b1, 1'b0, 36'hF_FFFF_FFFF, s);
    chk("R11 ab_full_a", ab_full_a, 0);
    @(negedge clk_b); @(negedge clk_b);
    chk("R11 ab_full_b", ab_full_b, 0);
    b_fetch("R11 ab word untouched");

    // R1 R4 R5 store A to B
    a_store(36'h9_A5C3_1E07, 1);
    chk("R4 ab_full_a", ab_full_a, 1);
    @(negedge clk_b); chk("R5 ab_full_b first edge", ab_full_b, 0);
    @(negedge clk_b); chk("R5 ab_full_b second edge", ab_full_b, 1);

    // R7 refused store while full
    a_store(36'h0_5555_AAAA, 0);
    chk("R7 ab_full_a still set", ab_full_a, 1);

    // R1 R9 fetch, R6 flag clearing
    b_fetch("R1 R9 ab word");
    chk("R6 ab_full_b cleared", ab_full_b, 0);
    @(negedge clk_a); chk("R6 ab_full_a first edge", ab_full_a, 1);
    @(negedge clk_a); chk("R6 ab_full_a second edge", ab_full_a, 0);

    // R8 non-destructive reread
    b_fetch("R8 ab reread");
    @(negedge clk_a); @(negedge clk_a);
    chk("R12 ab_full_a after reread", ab_full_a, 0);

    // R2 store B to A with flag timing
    b_store(36'h3_0F1E_2D4C, 1);
    chk("R4 ba_full_b", ba_full_b, 1);
    @(negedge clk_a); chk("R5 ba_full_a first edge", ba_full_a, 0);
    @(negedge clk_a); chk("R5 ba_full_a second edge", ba_full_a, 1);
    b_store(36'h7_7777_7777, 0);
    chk("R7 ba_full_b still set", ba_full_b, 1);
    a_fetch("R2 R9 ba word");
    chk("R6 ba_full_a cleared", ba_full_a, 0);
    @(negedge clk_b); chk("R6 ba_full_b first edge", ba_full_b, 1);
    @(negedge clk_b); chk("R6 ba_full_b second edge", ba_full_b, 0);
    a_fetch("R8 ba reread");

    // R9 more lane patterns
    for (int i = 0; i < 3; i++) begin
      logic [W-1:0] p;
      p = 36'h1_2345_6789 ^ (36'h0_F0F0_0F0F << i);
      a_store(p, 1);
      @(negedge clk_b); @(negedge clk_b);
      b_fetch("R9 lane pattern");
      repeat (3) @(negedge clk_a);
    end

    // R10 reset while mail is pending
    a_store(36'hC_0DE0_BEEF, 1);
    b_store(36'h2_4681_3579, 1);
    do_reset();
    chk("R10 ab_full_a mid", ab_full_a, 0); chk("R10 ab_full_b mid", ab_full_b, 0);
    chk("R10 ba_full_a mid", ba_full_a, 0); chk("R10 ba_full_b mid", ba_full_b, 0);
    b_fetch("R10 ab word cleared");
    a_fetch("R10 ba word cleared");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule